// File: doc/BRIEF.md
# Opcode Page Escape Countdown Stack

This block keeps track of which alternate opcode page is in force for the instructions that follow an escape instruction. Each escape command pushes a page selection together with a lifetime, counted in retired instructions. Only the top selection counts down, and it is removed on its own when the count runs out. A lifetime code of all ones makes a selection permanent: it stays until a command removes it. A retiring branch throws away every finite selection above the topmost permanent one. When the stack is empty, the decoder uses the default instruction set.

The front end sends one escape command per cycle: push a page, drop the top entry, or clear everything. It also sends strobes for each retired instruction and each retired branch. The decoder reads the active page number and an "active" flag, which together tell it which page decodes the next instruction. The whole state is packed into one 31-bit control register image. Software can read it at any time and can overwrite it in a single cycle. This lets a function call save and restore the page context.

All inputs are plain control strobes that are sampled on every clock edge. There is no valid/ready stream at this block's edge, so no input can be back-pressured. Every command and strobe takes effect in the cycle it is presented.

Top module: `page_escape_stack`

## Requirements
- R1: After reset the stack is empty: depth 0, all register-image entry bits 0, page_o 0, page_active_o 0, overflow_o 0.
- R2: A command with cmd_op_i = 2'b01 (push), a nonzero cmd_len_i and depth below 4 writes {length, page} into the entry at index depth and increments depth on the next edge. A push with length 0 changes nothing.
- R3: A push with nonzero length when depth is 4 leaves all state unchanged and drives overflow_o high for exactly the one cycle after the command.
- R4: cmd_op_i = 2'b10 (pop) removes the top entry. On an empty stack it has no effect.
- R5: cmd_op_i = 2'b11 (clear) empties the whole stack. Code 2'b00 with cmd_valid_i high counts as no command.
- R6: A retire_i strobe with no higher-priority event lowers the top entry's length by one when that length is finite (not 4'b1111). An entry whose length reaches 0 is removed. A permanent top entry and all entries below the top are left untouched.
- R7: A branch_i strobe with no higher-priority event removes entries from the top down until the top entry is permanent or the stack is empty.
- R8: When events coincide, priority runs from highest to lowest: register write, escape command, branch, retire. A retire in the same cycle as a command or a branch does not count down.
- R9: The register image csr_rdata_o holds entry i at bits [7i+6:7i], with the page in the low 3 bits of the entry and the length in the upper 4 bits. The depth is at bits [30:28]. A read reflects the current state. A write with csr_we_i loads the entries and the depth in one cycle.
- R10: A written depth above 4 is clamped to 4. Entries at indices at or above the depth always read as zero.
- R11: page_active_o is 1 exactly when depth is nonzero. page_o gives the page field of the top entry, and 0 when the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_i | input | 1 | One instruction retired this cycle |
| branch_i | input | 1 | A branch retired this cycle |
| cmd_valid_i | input | 1 | Escape command present |
| cmd_op_i | input | 2 | 00 none, 01 push, 10 pop, 11 clear |
| cmd_page_i | input | 3 | Page number for a push |
| cmd_len_i | input | 4 | Lifetime for a push, 4'b1111 permanent |
| csr_we_i | input | 1 | Load the register image |
| csr_wdata_i | input | 31 | Register image to load |
| csr_rdata_o | output | 31 | Current register image |
| page_o | output | 3 | Active page number |
| page_active_o | output | 1 | An alternate page is in force |
| depth_o | output | 3 | Number of stacked entries |
| overflow_o | output | 1 | Pulse: push refused on a full stack |

## Verification
The bench pushes into a full stack and checks that the stored entries stay as they are. A design that overwrote the top entry, or wrapped the depth to zero, would fail here. It retires instructions against permanent and length-1 tops. A wrong design would decrement a permanent entry, or leave behind a zero-length entry that still reports its page. It sends branches over stacks that mix finite and permanent entries to catch an unwind that stops one entry early or runs past the permanent one. It also presents coinciding events and register writes with an out-of-range depth. A design with the wrong priority would let a retire count down beside a command. A design without clamping would report a depth of 7 with stale entries still showing.

// File: rtl/pgstk_pkg.sv
package pgstk_pkg;

  typedef enum logic [1:0] {
    ESC_NONE  = 2'b00,
    ESC_PUSH  = 2'b01,
    ESC_POP   = 2'b10,
    ESC_CLEAR = 2'b11
  } esc_op_e;

  typedef enum logic [2:0] {
    EV_IDLE   = 3'd0,
    EV_CSR    = 3'd1,
    EV_CMD    = 3'd2,
    EV_BRANCH = 3'd3,
    EV_RETIRE = 3'd4
  } ev_e;

endpackage

// File: rtl/pgstk_arb.sv
module pgstk_arb
  import pgstk_pkg::*;
(
  input  logic       csr_we_i,
  input  logic       cmd_valid_i,
  input  logic [1:0] cmd_op_i,
  input  logic       branch_i,
  input  logic       retire_i,
  output ev_e        ev_o
);

  logic cmd_live;
  assign cmd_live = cmd_valid_i && (cmd_op_i != ESC_NONE);

  always_comb begin
    if (csr_we_i)      ev_o = EV_CSR;
    else if (cmd_live) ev_o = EV_CMD;
    else if (branch_i) ev_o = EV_BRANCH;
    else if (retire_i) ev_o = EV_RETIRE;
    else               ev_o = EV_IDLE;
  end

endmodule

// File: rtl/pgstk_unwind.sv
module pgstk_unwind #(
  parameter int N_ENT  = 4,
  parameter int PAGE_W = 3,
  parameter int LEN_W  = 4
) (
  input  logic [N_ENT*(PAGE_W+LEN_W)-1:0] ent_i,
  input  logic [$clog2(N_ENT+1)-1:0]      depth_i,
  output logic [$clog2(N_ENT+1)-1:0]      keep_o
);

  localparam int ENT_W = PAGE_W + LEN_W;
  localparam int DEP_W = $clog2(N_ENT + 1);

  logic [N_ENT-1:0] perm_live;

  for (genvar g = 0; g < N_ENT; g++) begin : g_perm
    assign perm_live[g] = (&ent_i[g*ENT_W+PAGE_W +: LEN_W]) &&
                          (DEP_W'(g) < depth_i);
  end

  // highest live permanent entry bounds the unwind
  always_comb begin
    keep_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (perm_live[i]) keep_o = DEP_W'(i + 1);
    end
  end

endmodule

// File: rtl/pgstk_next.sv
module pgstk_next
  import pgstk_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int PAGE_W = 3,
  parameter int LEN_W  = 4
) (
  input  ev_e                                           ev_i,
  input  logic [1:0]                                    cmd_op_i,
  input  logic [PAGE_W-1:0]                             cmd_page_i,
  input  logic [LEN_W-1:0]                              cmd_len_i,
  input  logic [N_ENT*(PAGE_W+LEN_W)+$clog2(N_ENT+1)-1:0] csr_wdata_i,
  input  logic [N_ENT*(PAGE_W+LEN_W)-1:0]               ent_i,
  input  logic [$clog2(N_ENT+1)-1:0]                    depth_i,
  input  logic [$clog2(N_ENT+1)-1:0]                    keep_i,
  output logic [N_ENT*(PAGE_W+LEN_W)-1:0]               ent_o,
  output logic [$clog2(N_ENT+1)-1:0]                    depth_o,
  output logic                                          ovf_o
);

  localparam int ENT_W = PAGE_W + LEN_W;
  localparam int DEP_W = $clog2(N_ENT + 1);
  localparam int STK_W = N_ENT * ENT_W;
  localparam logic [DEP_W-1:0] DEP_FULL = DEP_W'(N_ENT);
  localparam logic [LEN_W-1:0] LEN_PERM = '1;
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);

  logic [STK_W-1:0] ent_raw;
  logic [DEP_W-1:0] wr_dep;
  int               top_idx;
  logic [LEN_W-1:0] top_len;

  assign wr_dep  = csr_wdata_i[STK_W +: DEP_W];
  assign top_idx = (depth_i == '0) ? 0 : int'(depth_i) - 1;
  assign top_len = ent_i[top_idx*ENT_W+PAGE_W +: LEN_W];

  always_comb begin
    ent_raw = ent_i;
    depth_o = depth_i;
    ovf_o   = 1'b0;
    unique case (ev_i)
      EV_CSR: begin
        ent_raw = csr_wdata_i[STK_W-1:0];
        depth_o = (wr_dep > DEP_FULL) ? DEP_FULL : wr_dep;
      end
      EV_CMD: begin
        unique case (cmd_op_i)
          ESC_PUSH: begin
            if (cmd_len_i != '0) begin
              if (depth_i == DEP_FULL) begin
                ovf_o = 1'b1;
              end else begin
                ent_raw[int'(depth_i)*ENT_W +: ENT_W] = {cmd_len_i, cmd_page_i};
                depth_o = depth_i + DEP_W'(1);
              end
            end
          end
          ESC_POP: begin
            if (depth_i != '0) depth_o = depth_i - DEP_W'(1);
          end
          ESC_CLEAR: depth_o = '0;
          default: ;
        endcase
      end
      EV_BRANCH: depth_o = keep_i;
      EV_RETIRE: begin
        if (depth_i != '0 && top_len != LEN_PERM) begin
          if (top_len == LEN_ONE) depth_o = depth_i - DEP_W'(1);
          else ent_raw[top_idx*ENT_W+PAGE_W +: LEN_W] = top_len - LEN_ONE;
        end
      end
      default: ;
    endcase
  end

  // slots at or above the new depth are cleared
  always_comb begin
    ent_o = ent_raw;
    for (int i = 0; i < N_ENT; i++) begin
      if (DEP_W'(i) >= depth_o) ent_o[i*ENT_W +: ENT_W] = '0;
    end
  end

endmodule

// File: rtl/page_escape_stack.sv
module page_escape_stack
  import pgstk_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int PAGE_W = 3,
  parameter int LEN_W  = 4
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic                                             retire_i,
  input  logic                                             branch_i,
  input  logic                                             cmd_valid_i,
  input  logic [1:0]                                       cmd_op_i,
  input  logic [PAGE_W-1:0]                                cmd_page_i,
  input  logic [LEN_W-1:0]                                 cmd_len_i,
  input  logic                                             csr_we_i,
  input  logic [N_ENT*(PAGE_W+LEN_W)+$clog2(N_ENT+1)-1:0]  csr_wdata_i,
  output logic [N_ENT*(PAGE_W+LEN_W)+$clog2(N_ENT+1)-1:0]  csr_rdata_o,
  output logic [PAGE_W-1:0]                                page_o,
  output logic                                             page_active_o,
  output logic [$clog2(N_ENT+1)-1:0]                       depth_o,
  output logic                                             overflow_o
);

  localparam int ENT_W = PAGE_W + LEN_W;
  localparam int DEP_W = $clog2(N_ENT + 1);
  localparam int STK_W = N_ENT * ENT_W;
  localparam logic [DEP_W-1:0] DEP_FULL = DEP_W'(N_ENT);
  localparam logic [LEN_W-1:0] LEN_PERM = '1;

  logic [STK_W-1:0] ent_q, ent_d;
  logic [DEP_W-1:0] dep_q, dep_d, keep;
  logic             ovf_q, ovf_d;
  ev_e              ev;
  int               top_idx;
  logic [ENT_W-1:0] top_ent;
  logic [LEN_W-1:0] top_len;

  pgstk_arb u_arb (
    .csr_we_i    (csr_we_i),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .branch_i    (branch_i),
    .retire_i    (retire_i),
    .ev_o        (ev)
  );

  pgstk_unwind #(.N_ENT(N_ENT), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_unwind (
    .ent_i   (ent_q),
    .depth_i (dep_q),
    .keep_o  (keep)
  );

  pgstk_next #(.N_ENT(N_ENT), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_next (
    .ev_i        (ev),
    .cmd_op_i    (cmd_op_i),
    .cmd_page_i  (cmd_page_i),
    .cmd_len_i   (cmd_len_i),
    .csr_wdata_i (csr_wdata_i),
    .ent_i       (ent_q),
    .depth_i     (dep_q),
    .keep_i      (keep),
    .ent_o       (ent_d),
    .depth_o     (dep_d),
    .ovf_o       (ovf_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
      dep_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ent_q <= ent_d;
      dep_q <= dep_d;
      ovf_q <= ovf_d;
    end
  end

  assign top_idx = (dep_q == '0) ? 0 : int'(dep_q) - 1;
  assign top_ent = ent_q[top_idx*ENT_W +: ENT_W];
  assign top_len = top_ent[PAGE_W +: LEN_W];

  assign csr_rdata_o   = {dep_q, ent_q};
  assign depth_o       = dep_q;
  assign page_active_o = (dep_q != '0);
  assign page_o        = page_active_o ? top_ent[PAGE_W-1:0] : '0;
  assign overflow_o    = ovf_q;

  // R10
  dep_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dep_q <= DEP_FULL);

  // R3
  full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_CMD && cmd_op_i == ESC_PUSH && cmd_len_i != '0 && dep_q == DEP_FULL)
    |=> (ovf_q && $stable(dep_q) && $stable(ent_q)));

  // R4
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_CMD && cmd_op_i == ESC_POP && dep_q == '0) |=> (dep_q == '0));

  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_CMD && cmd_op_i == ESC_CLEAR) |=> (dep_q == '0 && ent_q == '0));

  // R6
  perm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_RETIRE && dep_q != '0 && top_len == LEN_PERM)
    |=> ($stable(dep_q) && $stable(ent_q)));

  // R7
  branch_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_BRANCH) |=> (dep_q == '0 || top_len == LEN_PERM));

endmodule

// File: tb/page_escape_stack_tb.sv
`timescale 1ns/1ps
module page_escape_stack_tb;

  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        retire_i = 0, branch_i = 0, cmd_valid_i = 0, csr_we_i = 0;
  logic [1:0]  cmd_op_i = 0;
  logic [2:0]  cmd_page_i = 0;
  logic [3:0]  cmd_len_i = 0;
  logic [30:0] csr_wdata_i = 0;
  logic [30:0] csr_rdata_o;
  logic [2:0]  page_o, depth_o;
  logic        page_active_o, overflow_o;

  page_escape_stack u_dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .branch_i(branch_i),
    .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i), .cmd_page_i(cmd_page_i),
    .cmd_len_i(cmd_len_i), .csr_we_i(csr_we_i), .csr_wdata_i(csr_wdata_i),
    .csr_rdata_o(csr_rdata_o), .page_o(page_o), .page_active_o(page_active_o),
    .depth_o(depth_o), .overflow_o(overflow_o)
  );

  always #2 clk = ~clk;

  int  total = 0, fails = 0;
  bit  done = 0;
  logic [6:0] m_ent [NE];
  int  m_dep = 0;
  bit  m_ovf = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [30:0] exp_csr();
    logic [30:0] v;
    v = '0;
    for (int i = 0; i < NE; i++) v[i*7 +: 7] = m_ent[i];
    v[30:28] = 3'(m_dep);
    return v;
  endfunction

  function automatic int exp_page();
    return (m_dep == 0) ? 0 : int'(m_ent[m_dep-1][2:0]);
  endfunction

  function automatic string tag_for(bit we, bit cv, logic [1:0] op, logic [3:0] ln, bit rt, bit br);
    if (we) return "R9";
    if (cv && op != 2'b00) begin
      if (op == 2'b01) return (m_dep == NE && ln != 0) ? "R3" : "R2";
      if (op == 2'b10) return "R4";
      return "R5";
    end
    if (br) return "R7";
    if (rt) return "R6";
    return "R8";
  endfunction

  task automatic model(input bit we, input logic [30:0] wd, input bit cv, input logic [1:0] op,
                       input logic [2:0] pg, input logic [3:0] ln, input bit rt, input bit br);
    m_ovf = 0;
    if (we) begin
      m_dep = int'(wd[30:28]);
      if (m_dep > NE) m_dep = NE;
      for (int i = 0; i < NE; i++) m_ent[i] = (i < m_dep) ? wd[i*7 +: 7] : 7'd0;
    end else if (cv && op != 2'b00) begin
      case (op)
        2'b01: if (ln != 0) begin
          if (m_dep == NE) m_ovf = 1;
          else begin m_ent[m_dep] = {ln, pg}; m_dep++; end
        end
        2'b10: if (m_dep > 0) begin m_dep--; m_ent[m_dep] = 0; end
        default: begin m_dep = 0; for (int i = 0; i < NE; i++) m_ent[i] = 0; end
      endcase
    end else if (br) begin
      while (m_dep > 0 && m_ent[m_dep-1][6:3] != 4'hF) begin
        m_dep--; m_ent[m_dep] = 0;
      end
    end else if (rt && m_dep > 0 && m_ent[m_dep-1][6:3] != 4'hF) begin
      if (m_ent[m_dep-1][6:3] == 4'd1) begin m_dep--; m_ent[m_dep] = 0; end
      else m_ent[m_dep-1][6:3] = m_ent[m_dep-1][6:3] - 4'd1;
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "csr", int'(csr_rdata_o), int'(exp_csr()));
    chk(tag, "depth", int'(depth_o), m_dep);
    chk(tag, "overflow", int'(overflow_o), int'(m_ovf));
    chk("R11", "page", int'(page_o), exp_page());
    chk("R11", "active", int'(page_active_o), int'(m_dep != 0));
  endtask

  task automatic step(input bit we, input logic [30:0] wd, input bit cv, input logic [1:0] op,
                      input logic [2:0] pg, input logic [3:0] ln, input bit rt, input bit br,
                      input string tag);
    csr_we_i = we; csr_wdata_i = wd; cmd_valid_i = cv; cmd_op_i = op;
    cmd_page_i = pg; cmd_len_i = ln; retire_i = rt; branch_i = br;
    model(we, wd, cv, op, pg, ln, rt, br);
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic push(input logic [2:0] pg, input logic [3:0] ln, input string tag);
    step(0, 0, 1, 2'b01, pg, ln, 0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd24681357);
    for (int i = 0; i < NE; i++) m_ent[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1");

    // R2 fill, zero-length push ignored
    push(3'd5, 4'd3, "R2");
    push(3'd6, 4'd0, "R2");
    push(3'd1, 4'hF, "R2");
    push(3'd2, 4'd2, "R2");
    push(3'd3, 4'd1, "R2");
    // R3 overflow on full stack, then pulse drops
    push(3'd7, 4'd4, "R3");
    step(0, 0, 0, 2'b00, 0, 0, 0, 0, "R3");
    // R8 pop with retire: only pop, retire ignored
    step(0, 0, 1, 2'b10, 0, 0, 1, 0, "R8");
    // R8 cmd_valid with none code lets retire act
    step(0, 0, 1, 2'b00, 0, 0, 1, 0, "R8");
    // R6 length 1 expires
    step(0, 0, 0, 2'b00, 0, 0, 1, 0, "R6");
    // R6 permanent top holds
    step(0, 0, 0, 2'b00, 0, 0, 1, 0, "R6");
    push(3'd4, 4'd5, "R2");
    push(3'd0, 4'd6, "R2");
    // R8 branch with retire: branch wins; R7 unwinds to permanent
    step(0, 0, 0, 2'b00, 0, 0, 1, 1, "R7");
    step(0, 0, 0, 2'b00, 0, 0, 0, 1, "R7");
    // R4 pops, including empty
    step(0, 0, 1, 2'b10, 0, 0, 0, 0, "R4");
    step(0, 0, 1, 2'b10, 0, 0, 0, 0, "R4");
    step(0, 0, 1, 2'b10, 0, 0, 0, 0, "R4");
    // R7 branch without permanent empties
    push(3'd2, 4'd9, "R2");
    push(3'd3, 4'd9, "R2");
    step(0, 0, 0, 2'b00, 0, 0, 0, 1, "R7");
    // R5 clear
    push(3'd2, 4'hF, "R2");
    push(3'd3, 4'd2, "R2");
    step(0, 0, 1, 2'b11, 0, 0, 0, 0, "R5");
    // R10 written depth 7 clamps to 4
    step(1, 31'h7FFF_FFFF, 0, 2'b00, 0, 0, 0, 0, "R10");
    // R9 write with push: write wins, high slots zeroed (R10)
    step(1, {3'd2, 7'h55, 7'h2A, 7'h1B, 7'h4C}, 1, 2'b01, 3'd1, 4'd1, 1, 1, "R9");

    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      bit we, cv, rt, br;
      logic [1:0] op;
      logic [2:0] pg;
      logic [3:0] ln;
      logic [30:0] wd;
      string tag;
      r  = $urandom % 100;
      we = (r < 3);
      cv = ($urandom % 100) < 30;
      op = 2'($urandom % 4);
      if (op == 2'b11 && ($urandom % 3) != 0) op = 2'b01;
      pg = 3'($urandom % 8);
      case ($urandom % 8)
        0: ln = 4'd0;
        1, 2: ln = 4'hF;
        default: ln = 4'(1 + $urandom % 3);
      endcase
      rt = ($urandom % 100) < 60;
      br = ($urandom % 100) < 8;
      wd = 31'($urandom);
      tag = tag_for(we, cv, op, ln, rt, br);
      step(we, wd, cv, op, pg, ln, rt, br, tag);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule